// File: doc/BRIEF.md
# Variable-Page-Size Data Translation Buffer

This block is a fully associative translation buffer for data accesses. It turns a virtual byte address into a physical byte address by searching all of its entries at once, and every entry holds its own page size. That size is one of four choices: 8 KB, 64 KB, 512 KB or 4 MB. The size of an entry decides which virtual page bits take part in its tag match and how many low address bits pass straight through into the physical address.

A lookup is purely combinational. The caller presents an address, a valid strobe and a store flag, and in the same cycle it gets hit, fault, a write-permission bit and the translated address. Software, or a page-walk engine outside this block, installs translations through a one-entry fill port. Victims are chosen by a rotating pointer, except when the new translation replaces one that is already present. A single invalidate input empties the whole buffer.

Top module: `dtlb_varpage`

## Requirements
- R1: After reset, and after any lookup with `lk_valid` low, `lk_hit`, `lk_fault` and `lk_writable` are 0 and `lk_paddr` is 0. A lookup that matches no valid entry gives the same all-zero result.
- R2: Lookup outputs depend combinationally on the current lookup inputs and the stored entries. An entry written by the fill port takes part in lookups from the cycle after `fill_en` is sampled, and not in the same cycle.
- R3: Size code s on `fill_size` (0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB) gives an offset of 13+3·s bits. An entry matches when its stored page number equals address bits [VA_W-1:13] on every page-number bit at position 3·s and above. The lower 3·s page-number bits are ignored.
- R4: On a match, `lk_paddr` bits below 13+3·s come from `lk_vaddr`, and bits from 13+3·s upward come from the entry's frame number. Frame bit j sits at physical bit 13+j.
- R5: When several valid entries match one lookup, the entry with the lowest index supplies the result.
- R6: A matching lookup with `lk_store` high on an entry whose write permission is 0 raises `lk_fault` and leaves `lk_hit` low. Every other matching lookup raises `lk_hit`. `lk_writable` equals the matching entry's write permission.
- R7: A fill that matches no existing entry writes the slot named by a replacement pointer. The pointer starts at 0 and steps by one per such fill, wrapping from ENTRIES-1 to 0.
- R8: A fill whose size equals that of a valid entry, and whose page number matches it under that size's mask (R3), rewrites the lowest-index such entry in place and leaves the replacement pointer unchanged.
- R9: `inval_all` clears every entry and returns the replacement pointer to 0, both taking effect at the next clock edge. A fill presented in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_store | input | 1 | Lookup is for a store |
| lk_vaddr | input | VA_W | Virtual byte address to translate |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_fault | output | 1 | Store to an entry without write permission |
| lk_writable | output | 1 | Write permission of the matching entry |
| lk_paddr | output | PA_W | Translated physical byte address |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | VA_W-13 | Virtual page number to install |
| fill_pfn | input | PA_W-13 | Physical frame number to install |
| fill_size | input | 2 | Page size code 0..3 |
| fill_wr_ok | input | 1 | Write permission of the new entry |
| inval_all | input | 1 | Empty the whole buffer |

## Verification
Lookup results are due in the same cycle as their inputs, so the bench sets inputs just after a falling edge and compares all four lookup outputs one nanosecond later, before the next rising edge. Fills and invalidations change state only at the rising edge. The bench's behavioural model therefore applies them after the comparison for that cycle, and their effect is first checked in the following cycle. This is how the same-cycle fill-then-lookup miss of R2 is pinned down. Directed sequences cover each page size, overlapping entries, in-place refills, pointer wrap and invalidate racing a fill. A long pseudo-random phase then draws from a small pool of page numbers so that overlaps and refills happen often.

// File: rtl/dtlb_pkg.sv
`timescale 1ns/1ps
// dtlb_pkg: constants and the page-size type shared by the translation buffer.
// Assumes the smallest page is 8 KB and that each size step adds 3 offset bits.
package dtlb_pkg;
    localparam int unsigned PAGE_LSB  = 13;
    localparam int unsigned SIZE_STEP = 3;

    typedef enum logic [1:0] {
        PGSZ_8K   = 2'd0,
        PGSZ_64K  = 2'd1,
        PGSZ_512K = 2'd2,
        PGSZ_4M   = 2'd3
    } pgsz_e;

    // Number of page-number bits that an entry of size sz leaves out of its match.
    function automatic int unsigned ignored_bits(input pgsz_e sz);
        return SIZE_STEP * int'(sz);
    endfunction
endpackage

// File: rtl/dtlb_entry_store.sv
`timescale 1ns/1ps
// dtlb_entry_store: the entry array (valid, page number, frame, size, permission).
// A write lands in slot wr_idx at the clock edge. Invalidate clears every valid bit
// and blocks a write in the same cycle. Assumes wr_idx < ENTRIES.
module dtlb_entry_store
    import dtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VPN_W   = 30,
    parameter int unsigned PFN_W   = 21,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inval_all,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [VPN_W-1:0]              wr_vpn,
    input  logic [PFN_W-1:0]              wr_pfn,
    input  pgsz_e                         wr_size,
    input  logic                          wr_perm,
    output logic [ENTRIES-1:0]            ent_valid,
    output logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    output logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn,
    output pgsz_e [ENTRIES-1:0]           ent_size,
    output logic [ENTRIES-1:0]            ent_perm
);
    // Valid bits: cleared by reset or invalidate, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || inval_all) begin
            ent_valid <= '0;
        end else if (wr_en) begin
            ent_valid[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: captured from the fill fields on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vpn  <= '0;
            ent_pfn  <= '0;
            ent_size <= {ENTRIES{PGSZ_8K}};
            ent_perm <= '0;
        end else if (wr_en && !inval_all) begin
            ent_vpn[wr_idx]  <= wr_vpn;
            ent_pfn[wr_idx]  <= wr_pfn;
            ent_size[wr_idx] <= wr_size;
            ent_perm[wr_idx] <= wr_perm;
        end
    end
endmodule

// File: rtl/dtlb_match.sv
`timescale 1ns/1ps
// dtlb_match: one comparator pair per entry. The lookup comparator masks the
// low page-number bits the entry's size covers. The fill comparator also
// requires the size to be equal, which finds a translation to rewrite in place.
module dtlb_match
    import dtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VPN_W   = 30
) (
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    input  pgsz_e [ENTRIES-1:0]           ent_size,
    input  logic [VPN_W-1:0]              lk_vpn,
    input  logic [VPN_W-1:0]              fill_vpn,
    input  pgsz_e                         fill_size,
    output logic [ENTRIES-1:0]            lk_match,
    output logic [ENTRIES-1:0]            fill_match
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [VPN_W-1:0] care;

        // Care mask: only page-number bits above the entry's offset take part.
        always_comb begin
            for (int j = 0; j < int'(VPN_W); j++) begin
                care[j] = (j >= int'(ignored_bits(ent_size[e])));
            end
        end

        // Match decisions for the lookup and the fill page numbers.
        always_comb begin
            lk_match[e]   = ent_valid[e] && (((ent_vpn[e] ^ lk_vpn) & care) == '0);
            fill_match[e] = ent_valid[e] && (ent_size[e] == fill_size)
                            && (((ent_vpn[e] ^ fill_vpn) & care) == '0);
        end
    end
endmodule

// File: rtl/dtlb_pick.sv
`timescale 1ns/1ps
// dtlb_pick: lowest-index priority select over a request vector.
// Returns whether any bit is set and the index of the lowest set bit.
module dtlb_pick #(
    parameter int unsigned N      = 32,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/dtlb_rr_ptr.sv
`timescale 1ns/1ps
// dtlb_rr_ptr: rotating victim pointer. Steps on each allocating fill, wraps at
// ENTRIES-1, and returns to 0 on reset or invalidate.
module dtlb_rr_ptr #(
    parameter int unsigned ENTRIES = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    // Pointer update with explicit wrap, so ENTRIES need not be a power of two.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/dtlb_varpage.sv
`timescale 1ns/1ps
// dtlb_varpage: fully associative data translation buffer with a page size per entry.
// Lookup is combinational. Fill and invalidate act at the clock edge.
// Assumes PA_W-13 <= VA_W-13 and PA_W-13 >= 9, so the largest page's offset
// splice stays inside both page-number fields.
module dtlb_varpage
    import dtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VA_W    = 43,
    parameter int unsigned PA_W    = 34,
    localparam int unsigned VPN_W  = VA_W - PAGE_LSB,
    localparam int unsigned PFN_W  = PA_W - PAGE_LSB,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_store,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_fault,
    output logic             lk_writable,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_size,
    input  logic             fill_wr_ok,
    input  logic             inval_all
);
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn;
    pgsz_e [ENTRIES-1:0]           ent_size;
    logic [ENTRIES-1:0]            ent_perm;
    logic [ENTRIES-1:0]            lk_match, fill_match;
    logic                          lk_any, fill_any;
    logic [IDX_W-1:0]              lk_idx, fill_idx, rr_ptr, wr_idx;
    logic [VPN_W-1:0]              lk_vpn;
    logic [PFN_W-1:0]              frame;
    pgsz_e                         fill_sz;
    pgsz_e                         sel_size;
    logic                          sel_perm;

    assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_LSB];
    assign fill_sz = pgsz_e'(fill_size);

    dtlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .inval_all (inval_all),
        .wr_en     (fill_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (fill_vpn),
        .wr_pfn    (fill_pfn),
        .wr_size   (fill_sz),
        .wr_perm   (fill_wr_ok),
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_pfn   (ent_pfn),
        .ent_size  (ent_size),
        .ent_perm  (ent_perm)
    );

    dtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .ent_valid  (ent_valid),
        .ent_vpn    (ent_vpn),
        .ent_size   (ent_size),
        .lk_vpn     (lk_vpn),
        .fill_vpn   (fill_vpn),
        .fill_size  (fill_sz),
        .lk_match   (lk_match),
        .fill_match (fill_match)
    );

    dtlb_pick #(.N(ENTRIES)) u_pick_lk (
        .req (lk_match & {ENTRIES{lk_valid}}),
        .any (lk_any),
        .idx (lk_idx)
    );

    dtlb_pick #(.N(ENTRIES)) u_pick_fill (
        .req (fill_match),
        .any (fill_any),
        .idx (fill_idx)
    );

    dtlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (inval_all),
        .step  (fill_en && !fill_any && !inval_all),
        .ptr   (rr_ptr)
    );

    // Fill target: rewrite a matching translation, otherwise take the victim slot.
    assign wr_idx = fill_any ? fill_idx : rr_ptr;

    // Selected entry fields for the winning lookup match.
    assign sel_size = ent_size[lk_idx];
    assign sel_perm = ent_perm[lk_idx];

    // Frame splice: low frame bits inside the page offset come from the address.
    always_comb begin
        for (int j = 0; j < int'(PFN_W); j++) begin
            frame[j] = (j < int'(ignored_bits(sel_size))) ? lk_vpn[j] : ent_pfn[lk_idx][j];
        end
    end

    // Lookup results: permission check and zeroed outputs when nothing matches.
    always_comb begin
        lk_fault    = lk_any && lk_store && !sel_perm;
        lk_hit      = lk_any && !lk_fault;
        lk_writable = lk_any && sel_perm;
        lk_paddr    = lk_any ? {frame, lk_vaddr[PAGE_LSB-1:0]} : '0;
    end
endmodule

// File: rtl/dtlb_varpage_chk.sv
`timescale 1ns/1ps
// dtlb_varpage_chk: protocol checks on the translation buffer, bound to its top.
// Looks only at ports and at the victim pointer.
module dtlb_varpage_chk #(
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_store,
    input logic [12:0]      va_off,
    input logic [12:0]      pa_off,
    input logic             lk_hit,
    input logic             lk_fault,
    input logic             lk_writable,
    input logic             fill_en,
    input logic             inval_all,
    input logic [IDX_W-1:0] rr_ptr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_fault && !lk_writable)); // R1
    AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault)); // R6
    AST_FAULT_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_store && !lk_writable)); // R6
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_fault) |-> (pa_off == va_off)); // R4
    AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (!lk_hit && !lk_fault)); // R9
    AST_INVAL_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (rr_ptr == '0)); // R9
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !inval_all) |=> $stable(rr_ptr)); // R7
endmodule

bind dtlb_varpage dtlb_varpage_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_store    (lk_store),
    .va_off      (lk_vaddr[12:0]),
    .pa_off      (lk_paddr[12:0]),
    .lk_hit      (lk_hit),
    .lk_fault    (lk_fault),
    .lk_writable (lk_writable),
    .fill_en     (fill_en),
    .inval_all   (inval_all),
    .rr_ptr      (rr_ptr)
);

// File: tb/dtlb_varpage_bench.sv
`timescale 1ns/1ps
// dtlb_varpage_bench: behavioural reference model compared on every cycle.
module dtlb_varpage_bench;
    localparam int ENTRIES = 32;
    localparam int VA_W    = 43;
    localparam int PA_W    = 34;
    localparam int LSB     = 13;
    localparam int VPN_W   = VA_W - LSB;
    localparam int PFN_W   = PA_W - LSB;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0, lk_store = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic             lk_hit, lk_fault, lk_writable;
    logic [PA_W-1:0]  lk_paddr;
    logic             fill_en = 1'b0, fill_wr_ok = 1'b0, inval_all = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [1:0]       fill_size = '0;

    always #4 clk = ~clk;

    dtlb_varpage #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u_dtlb_varpage (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_store(lk_store),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_fault(lk_fault),
        .lk_writable(lk_writable), .lk_paddr(lk_paddr), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_size(fill_size),
        .fill_wr_ok(fill_wr_ok), .inval_all(inval_all)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model state.
    bit          m_val [ENTRIES];
    logic [63:0] m_vpn [ENTRIES];
    logic [63:0] m_pfn [ENTRIES];
    int          m_sz  [ENTRIES];
    bit          m_wr  [ENTRIES];
    int          m_ptr;

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: compare lookup outputs before the edge, then update the model.
    task automatic tick(string tag);
        bit          any;
        int          idx;
        logic [63:0] va, vpn, lo, epa;
        bit          efault;
        #1;
        any = 0; idx = 0; epa = '0;
        va  = 64'(lk_vaddr);
        vpn = va >> LSB;
        if (lk_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!any && m_val[i] && (((m_vpn[i] ^ vpn) >> (3 * m_sz[i])) == 0)) begin
                    any = 1; idx = i;
                end
            end
        end
        if (any) begin
            lo  = (64'd1 << (LSB + 3 * m_sz[idx])) - 64'd1;
            epa = (((m_pfn[idx] << LSB) & ~lo) | (va & lo)) & ((64'd1 << PA_W) - 64'd1);
        end
        efault = any && lk_store && !m_wr[idx];
        check(tag, "hit",      64'(lk_hit),      64'(any && !efault));
        check(tag, "fault",    64'(lk_fault),    64'(efault));
        check(tag, "writable", 64'(lk_writable), 64'(any && m_wr[idx]));
        check(tag, "paddr",    64'(lk_paddr),    epa);
        @(posedge clk);
        if (inval_all) begin
            for (int i = 0; i < ENTRIES; i++) m_val[i] = 0;
            m_ptr = 0;
        end else if (fill_en) begin
            int slot;
            slot = -1;
            for (int i = 0; i < ENTRIES; i++) begin
                if (slot < 0 && m_val[i] && m_sz[i] == int'(fill_size)
                    && (((m_vpn[i] ^ 64'(fill_vpn)) >> (3 * int'(fill_size))) == 0))
                    slot = i;
            end
            if (slot < 0) begin
                slot  = m_ptr;
                m_ptr = (m_ptr + 1) % ENTRIES;
            end
            m_val[slot] = 1;
            m_vpn[slot] = 64'(fill_vpn);
            m_pfn[slot] = 64'(fill_pfn);
            m_sz[slot]  = int'(fill_size);
            m_wr[slot]  = fill_wr_ok;
        end
        @(negedge clk);
    endtask

    task automatic do_fill(logic [63:0] vpn, logic [63:0] pfn, int sz, bit wr, string tag);
        lk_valid = 0; fill_en = 1;
        fill_vpn = vpn[VPN_W-1:0]; fill_pfn = pfn[PFN_W-1:0];
        fill_size = 2'(sz); fill_wr_ok = wr;
        tick(tag);
        fill_en = 0;
    endtask

    task automatic do_look(logic [63:0] vpn, logic [63:0] off, bit st, string tag);
        logic [63:0] va;
        va = (vpn << LSB) | (off & 64'h1fff);
        lk_valid = 1; lk_store = st; lk_vaddr = va[VA_W-1:0];
        tick(tag);
        lk_valid = 0; lk_store = 0;
    endtask

    // Lookup with a full offset inside a large page.
    task automatic do_look_va(logic [63:0] va, bit st, string tag);
        lk_valid = 1; lk_store = st; lk_vaddr = va[VA_W-1:0];
        tick(tag);
        lk_valid = 0; lk_store = 0;
    endtask

    initial begin : main
        logic [63:0] r;
        for (int i = 0; i < ENTRIES; i++) begin
            m_val[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_sz[i] = 0; m_wr[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: empty after reset.
        do_look(64'h100, 64'h10, 0, "R1");
        // R2: fill and lookup in the same cycle miss, then hit next cycle.
        lk_valid = 1; lk_vaddr = VA_W'((64'h100 << LSB) | 64'h1234);
        do_fill(64'h100, 64'h0ab, 0, 1, "R2");
        do_look(64'h100, 64'h1234, 0, "R2");
        do_look(64'h100, 64'h1234, 1, "R6");
        // R1: strobe low gives nothing even on a hitting address.
        lk_valid = 0; lk_vaddr = VA_W'((64'h100 << LSB) | 64'h5);
        tick("R1");
        // R3/R4: 64 KB entry ignores 3 low page bits.
        do_fill(64'h208, 64'h155, 1, 0, "R3");
        do_look_va((64'h20f << LSB) | 64'h1abc, 0, "R4");
        do_look_va((64'h20f << LSB) | 64'h0123, 1, "R6");
        do_look(64'h210, 64'h0, 0, "R3");
        // R3/R4: 512 KB and 4 MB entries.
        do_fill(64'h4000, 64'h1c0, 2, 1, "R3");
        do_look_va((64'h403f << LSB) | 64'h1fff, 0, "R4");
        do_look(64'h4040, 64'h0, 0, "R3");
        do_fill(64'h80000, 64'h1ffe00, 3, 1, "R3");
        do_look_va((64'h801ff << LSB) | 64'h0777, 1, "R4");
        // R5: overlapping 8 KB entry at a higher index loses to the 4 MB one.
        do_fill(64'h80005, 64'h33, 0, 0, "R5");
        do_look(64'h80005, 64'h40, 1, "R5");
        // R8: in-place refill of vpn 0x100 changes frame and permission.
        do_fill(64'h100, 64'h0cc, 0, 0, "R8");
        do_look(64'h100, 64'h8, 0, "R8");
        do_look(64'h100, 64'h8, 1, "R8");
        do_fill(64'h300, 64'h77, 0, 1, "R8");
        do_look(64'h300, 64'h0, 0, "R8");
        // R7: wrap the victim pointer; early entries get evicted.
        for (int k = 0; k < 40; k++) do_fill(64'h1000 + 64'(k), 64'h500 + 64'(k), 0, 1, "R7");
        do_look(64'h100, 64'h0, 0, "R7");
        do_look(64'h1000, 64'h0, 0, "R7");
        do_look(64'h1027, 64'h2, 0, "R7");
        // R9: invalidate racing a fill; the fill is dropped.
        inval_all = 1;
        do_fill(64'h2222, 64'h1, 0, 1, "R9");
        inval_all = 0;
        do_look(64'h2222, 64'h0, 0, "R9");
        do_look(64'h1027, 64'h0, 0, "R9");
        for (int k = 0; k < 33; k++) do_fill(64'h3000 + 64'(k), 64'h600 + 64'(k), 0, 1, "R9");
        do_look(64'h3000, 64'h0, 0, "R9");
        do_look(64'h3001, 64'h0, 0, "R9");

        // Pseudo-random phase over a small page pool.
        r = 64'h9e3779b97f4a7c15;
        for (int n = 0; n < 4000; n++) begin
            r = r ^ (r << 13); r = r ^ (r >> 7); r = r ^ (r << 17);
            inval_all  = (r[9:0] == 10'd3);
            fill_en    = (r[12:10] < 3'd3);
            fill_vpn   = VPN_W'({r[20:13]});
            fill_pfn   = PFN_W'(r[41:21]);
            fill_size  = r[43:42];
            fill_wr_ok = r[44];
            lk_valid   = r[45] | r[46];
            lk_store   = r[47];
            lk_vaddr   = VA_W'({r[55:48], r[62:50]});
            tick("R3");
        end
        inval_all = 0; fill_en = 0; lk_valid = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule